// File: doc/BRIEF.md
# Wrapping Address Register Generator

This block keeps the pointer state for a small address-generation unit: four address registers, four index registers and four wrap masks. A 2-bit selector picks one entry of each bank at once, so an address register always works with its own index and its own mask. Two independent update lanes each name an address register and a step operation: hold, step up, step down, or add the signed index. Each lane returns the new pointer value combinationally, so the unit that owns the writeback log can use it in the same cycle. When the lane's commit input is high, that value is written back at the next clock edge.

The wrap mask sets a modulo window inside the pointer. Stepping down from a pointer whose masked bits are all zero jumps to the top of the window. Stepping up from a pointer whose masked bits are all one falls back to the bottom of the window. Bits outside the mask are left untouched by a wrap. The index add ignores the mask and simply wraps modulo 2^16. A plain write port loads any register of any bank. A registered read port returns any register one cycle after it is addressed.

Top module: `wrapaddr_top`

## Requirements
- R1: After a synchronous reset, every address register and every index register reads 0x0000, and every wrap mask reads 0xFFFF.
- R2: The write port loads `wr_data` into entry `wr_sel` of the bank named by `wr_bank` (0 address, 1 index, 2 wrap mask) at the clock edge where `wr_en` is high. Bank code 3 changes no register.
- R3: `rd_data` shows the register chosen by `rd_bank` and `rd_sel` (same bank codes as R2; code 3 reads 0x0000), as it stood before the clock edge that samples the request. The value appears one cycle after the request.
- R4: Operation code 1 (step up) returns `ar & ~wp` when `(ar & wp) == wp`, and returns `ar + 1` otherwise.
- R5: Operation code 2 (step down) returns `ar | wp` when `(ar & wp) == 0`, and returns `ar - 1` otherwise.
- R6: Operation code 3 returns `ar + ix`, with `ix` taken as a signed 16-bit value. The sum wraps modulo 2^16 and the mask has no effect on it.
- R7: Operation code 0 returns the selected address register unchanged.
- R8: A lane with its commit input high writes its result into the selected address register at the next edge. No address register changes unless a commit or a write to bank 0 names it.
- R9: Both lanes compute and commit in the same cycle on different registers. Each lane uses the index and mask paired with its own selector.
- R10: When writes collide on one address register in a cycle, lane A wins over lane B, and both lanes win over the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Direct write enable |
| wr_bank | input | 2 | Bank for the direct write (0 addr, 1 index, 2 mask, 3 none) |
| wr_sel | input | 2 | Entry for the direct write |
| wr_data | input | 16 | Direct write data |
| rd_bank | input | 2 | Bank for the read |
| rd_sel | input | 2 | Entry for the read |
| rd_data | output | 16 | Registered read data |
| a_op | input | 2 | Lane A operation (0 hold, 1 up, 2 down, 3 add index) |
| a_sel | input | 2 | Lane A register selector |
| a_commit | input | 1 | Lane A writes its result back |
| a_res | output | 16 | Lane A updated pointer (combinational) |
| b_op | input | 2 | Lane B operation |
| b_sel | input | 2 | Lane B register selector |
| b_commit | input | 1 | Lane B writes its result back |
| b_res | output | 16 | Lane B updated pointer (combinational) |

## Verification
A corrupted address register shows up in the same cycle as a wrong lane result whenever a lane selects it, even with operation 0. A corrupted index or mask only shows on an add, or on a step that reaches a window edge. Those registers are therefore also read back through the one-cycle read port. The bench keeps its own copy of all twelve registers and compares both lane results every cycle. Wrap edges are run with masks that are empty, narrow, non-contiguous and full, so that a wrong mask shows up within a few updates.

// File: rtl/wrapaddr_pkg.sv
package wrapaddr_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_IDX  = 2'd3
  } step_op_e;

  typedef enum logic [1:0] {
    BANK_ADDR = 2'd0,
    BANK_IDX  = 2'd1,
    BANK_MASK = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;
endpackage

// File: rtl/wrapaddr_bank.sv
module wrapaddr_bank #(
  parameter int DW = 16,
  parameter int NREG = 4,
  parameter int NLANE = 2,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [$clog2(NREG)-1:0] wr_sel,
  input  logic [DW-1:0]         wr_data,
  input  logic [NLANE-1:0]      cm_en,
  input  logic [NLANE*$clog2(NREG)-1:0] cm_sel,
  input  logic [NLANE*DW-1:0]   cm_data,
  output logic [NREG*DW-1:0]    q_flat
);
  localparam int SW = $clog2(NREG);

  for (genvar e = 0; e < NREG; e++) begin : g_entry
    logic [DW-1:0] q, nxt;

    // Priority: write port lowest, then higher lanes, lane 0 last (wins).
    always_comb begin
      nxt = q;
      if (wr_en && wr_sel == SW'(e)) nxt = wr_data;
      for (int l = NLANE - 1; l >= 0; l--) begin
        if (cm_en[l] && cm_sel[l*SW +: SW] == SW'(e)) nxt = cm_data[l*DW +: DW];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= nxt;
    end

    assign q_flat[e*DW +: DW] = q;
  end
endmodule

// File: rtl/wrapaddr_step.sv
module wrapaddr_step
  import wrapaddr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]    op,
  input  logic [DW-1:0] ar,
  input  logic [DW-1:0] ix,
  input  logic [DW-1:0] wp,
  output logic [DW-1:0] res
);
  logic [DW-1:0] masked;
  logic          at_top, at_bottom;

  assign masked    = ar & wp;
  assign at_top    = (masked == wp);
  assign at_bottom = (masked == '0);

  always_comb begin
    unique case (step_op_e'(op))
      STEP_UP:   res = at_top    ? (ar & ~wp) : ar + DW'(1);
      STEP_DOWN: res = at_bottom ? (ar | wp)  : ar - DW'(1);
      STEP_IDX:  res = ar + ix;
      default:   res = ar;
    endcase
  end
endmodule

// File: rtl/wrapaddr_rdport.sv
module wrapaddr_rdport
  import wrapaddr_pkg::*;
#(
  parameter int DW = 16,
  parameter int NREG = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              rd_bank,
  input  logic [$clog2(NREG)-1:0] rd_sel,
  input  logic [NREG*DW-1:0]      ar_flat,
  input  logic [NREG*DW-1:0]      ix_flat,
  input  logic [NREG*DW-1:0]      wp_flat,
  output logic [DW-1:0]           rd_data
);
  logic [DW-1:0] mux_val;

  always_comb begin
    unique case (bank_e'(rd_bank))
      BANK_ADDR: mux_val = ar_flat[rd_sel*DW +: DW];
      BANK_IDX:  mux_val = ix_flat[rd_sel*DW +: DW];
      BANK_MASK: mux_val = wp_flat[rd_sel*DW +: DW];
      default:   mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mux_val;
  end
endmodule

// File: rtl/wrapaddr_top.sv
module wrapaddr_top
  import wrapaddr_pkg::*;
#(
  parameter int DW = 16,
  parameter int NREG = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_bank,
  input  logic [$clog2(NREG)-1:0] wr_sel,
  input  logic [DW-1:0]           wr_data,
  input  logic [1:0]              rd_bank,
  input  logic [$clog2(NREG)-1:0] rd_sel,
  output logic [DW-1:0]           rd_data,
  input  logic [1:0]              a_op,
  input  logic [$clog2(NREG)-1:0] a_sel,
  input  logic                    a_commit,
  output logic [DW-1:0]           a_res,
  input  logic [1:0]              b_op,
  input  logic [$clog2(NREG)-1:0] b_sel,
  input  logic                    b_commit,
  output logic [DW-1:0]           b_res
);
  localparam int SW = $clog2(NREG);
  localparam int NLANE = 2;

  logic [NREG*DW-1:0]  ar_flat, ix_flat, wp_flat;
  logic [NLANE*2-1:0]  lane_op;
  logic [NLANE*SW-1:0] lane_sel;
  logic [NLANE-1:0]    lane_cm;
  logic [NLANE*DW-1:0] lane_res;

  // Lane 0 is lane A (highest priority), lane 1 is lane B.
  assign lane_op  = {b_op, a_op};
  assign lane_sel = {b_sel, a_sel};
  assign lane_cm  = {b_commit, a_commit};
  assign a_res    = lane_res[0 +: DW];
  assign b_res    = lane_res[DW +: DW];

  logic wr_addr, wr_idx, wr_mask;
  assign wr_addr = wr_en && (bank_e'(wr_bank) == BANK_ADDR);
  assign wr_idx  = wr_en && (bank_e'(wr_bank) == BANK_IDX);
  assign wr_mask = wr_en && (bank_e'(wr_bank) == BANK_MASK);

  wrapaddr_bank #(.DW(DW), .NREG(NREG), .NLANE(NLANE), .RST_VAL('0)) addr_bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_addr), .wr_sel(wr_sel), .wr_data(wr_data),
    .cm_en(lane_cm), .cm_sel(lane_sel), .cm_data(lane_res), .q_flat(ar_flat)
  );

  wrapaddr_bank #(.DW(DW), .NREG(NREG), .NLANE(1), .RST_VAL('0)) idx_bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
    .cm_en(1'b0), .cm_sel('0), .cm_data('0), .q_flat(ix_flat)
  );

  wrapaddr_bank #(.DW(DW), .NREG(NREG), .NLANE(1), .RST_VAL('1)) mask_bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_mask), .wr_sel(wr_sel), .wr_data(wr_data),
    .cm_en(1'b0), .cm_sel('0), .cm_data('0), .q_flat(wp_flat)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [SW-1:0] s;
    assign s = lane_sel[l*SW +: SW];

    wrapaddr_step #(.DW(DW)) step_i (
      .op (lane_op[l*2 +: 2]),
      .ar (ar_flat[s*DW +: DW]),
      .ix (ix_flat[s*DW +: DW]),
      .wp (wp_flat[s*DW +: DW]),
      .res(lane_res[l*DW +: DW])
    );
  end

  wrapaddr_rdport #(.DW(DW), .NREG(NREG)) rdport_i (
    .clk(clk), .rst(rst), .rd_bank(rd_bank), .rd_sel(rd_sel),
    .ar_flat(ar_flat), .ix_flat(ix_flat), .wp_flat(wp_flat), .rd_data(rd_data)
  );
endmodule

// File: rtl/wrapaddr_chk.sv
module wrapaddr_chk #(
  parameter int DW = 16,
  parameter int NREG = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NREG*DW-1:0]      ar_flat,
  input logic [NREG*DW-1:0]      ix_flat,
  input logic [NREG*DW-1:0]      wp_flat,
  input logic                    wr_en,
  input logic [1:0]              wr_bank,
  input logic [1:0]              a_op,
  input logic [$clog2(NREG)-1:0] a_sel,
  input logic                    a_commit,
  input logic [DW-1:0]           a_res,
  input logic                    b_commit
);
  localparam int SW = $clog2(NREG);

  function automatic logic [DW-1:0] pick(input logic [NREG*DW-1:0] flat, input logic [SW-1:0] s);
    return flat[s*DW +: DW];
  endfunction

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_seen && !rst) begin
      reset_state_chk: assert (ar_flat == '0 && ix_flat == '0 && wp_flat == '1);
    end
  end

  // R7
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    a_op == 2'd0 |-> a_res == pick(ar_flat, a_sel));

  // R5
  down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (a_op == 2'd2 && (pick(ar_flat, a_sel) & pick(wp_flat, a_sel)) == '0)
    |-> a_res == (pick(ar_flat, a_sel) | pick(wp_flat, a_sel)));

  // R4
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (a_op == 2'd1 && (pick(ar_flat, a_sel) & pick(wp_flat, a_sel)) == pick(wp_flat, a_sel))
    |-> a_res == (pick(ar_flat, a_sel) & ~pick(wp_flat, a_sel)));

  // R6
  idx_add_chk: assert property (@(posedge clk) disable iff (rst)
    a_op == 2'd3 |-> a_res == pick(ar_flat, a_sel) + pick(ix_flat, a_sel));

  // R10
  commit_a_chk: assert property (@(posedge clk) disable iff (rst)
    a_commit |=> pick(ar_flat, $past(a_sel)) == $past(a_res));

  // R8
  addr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_commit && !b_commit && !(wr_en && wr_bank == 2'd0)) |=> $stable(ar_flat));
endmodule

bind wrapaddr_top wrapaddr_chk #(.DW(DW), .NREG(NREG)) chk_i (
  .clk(clk), .rst(rst), .ar_flat(ar_flat), .ix_flat(ix_flat), .wp_flat(wp_flat),
  .wr_en(wr_en), .wr_bank(wr_bank), .a_op(a_op), .a_sel(a_sel),
  .a_commit(a_commit), .a_res(a_res), .b_commit(b_commit)
);

// File: tb/wrapaddr_tb.sv
module wrapaddr_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_bank = '0, wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_bank = '0, rd_sel = '0;
  logic [15:0] rd_data;
  logic [1:0]  a_op = '0, a_sel = '0, b_op = '0, b_sel = '0;
  logic        a_commit = 1'b0, b_commit = 1'b0;
  logic [15:0] a_res, b_res;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_ar [4];
  logic [15:0] m_ix [4];
  logic [15:0] m_wp [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  wrapaddr_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_bank(rd_bank), .rd_sel(rd_sel), .rd_data(rd_data),
    .a_op(a_op), .a_sel(a_sel), .a_commit(a_commit), .a_res(a_res),
    .b_op(b_op), .b_sel(b_sel), .b_commit(b_commit), .b_res(b_res)
  );

  function automatic logic [15:0] exp_step(input logic [1:0] op, input logic [15:0] ar,
                                           input logic [15:0] ix, input logic [15:0] wp);
    case (op)
      2'd1: return ((ar & wp) == wp) ? (ar & ~wp) : ar + 16'd1;
      2'd2: return ((ar & wp) == 16'd0) ? (ar | wp) : ar - 16'd1;
      2'd3: return ar + ix;
      default: return ar;
    endcase
  endfunction

  function automatic logic [15:0] exp_read(input logic [1:0] bank, input logic [1:0] s);
    case (bank)
      2'd0: return m_ar[s];
      2'd1: return m_ix[s];
      2'd2: return m_wp[s];
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, check lane results, let the edge commit, update model.
  task automatic cyc(input logic we, input logic [1:0] wb, input logic [1:0] ws,
                     input logic [15:0] wd, input logic [1:0] aop, input logic [1:0] asel,
                     input logic acm, input logic [1:0] bop, input logic [1:0] bsel,
                     input logic bcm, input string req);
    logic [15:0] ea, eb;
    @(negedge clk);
    wr_en = we; wr_bank = wb; wr_sel = ws; wr_data = wd;
    a_op = aop; a_sel = asel; a_commit = acm;
    b_op = bop; b_sel = bsel; b_commit = bcm;
    #1;
    ea = exp_step(aop, m_ar[asel], m_ix[asel], m_wp[asel]);
    eb = exp_step(bop, m_ar[bsel], m_ix[bsel], m_wp[bsel]);
    chk({req, " lane A"}, a_res, ea);
    chk({req, " lane B"}, b_res, eb);
    @(posedge clk);
    if (we) begin
      if (wb == 2'd0) m_ar[ws] = wd;
      else if (wb == 2'd1) m_ix[ws] = wd;
      else if (wb == 2'd2) m_wp[ws] = wd;
    end
    if (bcm) m_ar[bsel] = eb;
    if (acm) m_ar[asel] = ea;
    @(negedge clk);
    wr_en = 1'b0; a_commit = 1'b0; b_commit = 1'b0; a_op = 2'd0; b_op = 2'd0;
  endtask

  task automatic rd_chk(input logic [1:0] bank, input logic [1:0] s, input string req);
    @(negedge clk);
    rd_bank = bank; rd_sel = s;
    @(negedge clk);
    chk(req, rd_data, exp_read(bank, s));
  endtask

  task automatic wr(input logic [1:0] bank, input logic [1:0] s, input logic [15:0] d);
    cyc(1'b1, bank, s, d, 2'd0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b0, "R2 write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] masks [6];
    void'($urandom(32'd20240917));
    masks[0] = 16'hFFFF; masks[1] = 16'h000F; masks[2] = 16'h00F0;
    masks[3] = 16'h0007; masks[4] = 16'h0000; masks[5] = 16'h0F0F;
    for (int i = 0; i < 4; i++) begin
      m_ar[i] = 16'h0000; m_ix[i] = 16'h0000; m_wp[i] = 16'hFFFF;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state of all three banks
    for (int i = 0; i < 4; i++) begin
      rd_chk(2'd0, 2'(i), "R1 addr reset");
      rd_chk(2'd1, 2'(i), "R1 index reset");
      rd_chk(2'd2, 2'(i), "R1 mask reset");
    end

    // R2: direct writes, and bank code 3 ignored
    wr(2'd0, 2'd1, 16'h1234);
    wr(2'd1, 2'd1, 16'hFFFE);
    wr(2'd2, 2'd1, 16'h000F);
    cyc(1'b1, 2'd3, 2'd1, 16'hAAAA, 2'd0, 2'd1, 1'b0, 2'd0, 2'd2, 1'b0, "R2 bank3");
    rd_chk(2'd0, 2'd1, "R2 addr readback");
    rd_chk(2'd1, 2'd1, "R2 index readback");
    rd_chk(2'd2, 2'd1, "R2 mask readback");
    rd_chk(2'd3, 2'd1, "R3 bank3 reads zero");

    // R3: read latency of one cycle
    @(negedge clk); rd_bank = 2'd0; rd_sel = 2'd0;
    @(negedge clk); chk("R3 prior value", rd_data, 16'h0000);
    rd_bank = 2'd0; rd_sel = 2'd1;
    #1; chk("R3 not yet updated", rd_data, 16'h0000);
    @(negedge clk); chk("R3 after one edge", rd_data, 16'h1234);

    // R4: step up inside window, then at window top
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd1, 2'd1, 1'b1, 2'd0, 2'd0, 1'b0, "R4 up inner");
    wr(2'd0, 2'd1, 16'h123F);
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd1, 2'd1, 1'b1, 2'd0, 2'd0, 1'b0, "R4 up wrap");
    rd_chk(2'd0, 2'd1, "R4 wrapped to 0x1230");
    // R5: step down from window bottom, then inside
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd2, 2'd1, 1'b1, 2'd0, 2'd0, 1'b0, "R5 down wrap");
    rd_chk(2'd0, 2'd1, "R5 wrapped to 0x123F");
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd2, 2'd1, 1'b1, 2'd0, 2'd0, 1'b0, "R5 down inner");
    // R4 R5: full mask wraps the whole range; empty mask holds
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd2, 2'd0, 1'b1, 2'd1, 2'd0, 1'b0, "R5 full mask");
    wr(2'd2, 2'd2, 16'h0000);
    wr(2'd0, 2'd2, 16'h5555);
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd1, 2'd2, 1'b0, 2'd2, 2'd2, 1'b0, "R4 R5 empty mask");

    // R6: signed index add ignores the mask
    wr(2'd0, 2'd1, 16'h0001);
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd3, 2'd1, 1'b1, 2'd0, 2'd0, 1'b0, "R6 negative index");
    rd_chk(2'd0, 2'd1, "R6 result 0xFFFF");
    // R7: hold returns the register and does not commit change
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd0, 2'd1, 1'b1, 2'd0, 2'd3, 1'b0, "R7 hold");

    // R9: two lanes on different registers
    wr(2'd1, 2'd3, 16'h0100);
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd3, 2'd3, 1'b1, 2'd2, 2'd1, 1'b1, "R9 dual");
    rd_chk(2'd0, 2'd3, "R9 lane A target");
    rd_chk(2'd0, 2'd1, "R9 lane B target");

    // R10: collisions
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd1, 2'd0, 1'b1, 2'd2, 2'd0, 1'b1, "R10 A over B");
    rd_chk(2'd0, 2'd0, "R10 lane A wins");
    cyc(1'b1, 2'd0, 2'd3, 16'hBEEF, 2'd0, 2'd0, 1'b0, 2'd1, 2'd3, 1'b1, "R10 lane over write");
    rd_chk(2'd0, 2'd3, "R10 lane B beats write port");
    // R8: no commit leaves register unchanged
    cyc(1'b0, 2'd0, 2'd0, 16'h0, 2'd1, 2'd3, 1'b0, 2'd2, 2'd3, 1'b0, "R8 no commit");
    rd_chk(2'd0, 2'd3, "R8 unchanged");

    // Random mix of writes and lane updates
    for (int n = 0; n < 400; n++) begin
      logic [1:0] as, bs;
      logic [15:0] d;
      as = 2'($urandom_range(0, 3));
      bs = 2'($urandom_range(0, 3));
      if (bs == as) bs = as + 2'd1;
      case ($urandom_range(0, 5))
        0: d = masks[$urandom_range(0, 5)];
        default: d = 16'($urandom);
      endcase
      if ($urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 1) == 1) wr(2'd2, as, masks[$urandom_range(0, 5)]);
        else wr(2'($urandom_range(0, 1)), as, d);
      end
      cyc(1'($urandom_range(0, 4) == 0), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), d,
          2'($urandom_range(0, 3)), as, 1'($urandom_range(0, 1)),
          2'($urandom_range(0, 3)), bs, 1'($urandom_range(0, 1)), "R9 random");
      if (n % 16 == 0) rd_chk(2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)), "R3 random read");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule